// File: doc/BRIEF.md
# Even-Ratio Serial Clock Generator

This block derives the serial clock of an SPI master from a fast system clock. A 16-bit divisor setting picks the ratio between the two clocks. Any even ratio from 2 up to 65536 can be reached. Bit 0 of the setting is dropped, so odd settings round down to the even value below them. A setting of 0 or 1 selects the largest ratio, 65536. The fastest serial clock is therefore half the system clock.

While the enable input is low, the serial clock rests at the idle level given by the polarity input, and the block takes in the divisor and the polarity. Once enable goes high, those two values are frozen for the whole transfer. The serial clock then toggles every half-ratio system cycles, which gives a 50% duty cycle. The first toggle comes one half period after enable, not at once.

Two single-cycle strobes go to the shift logic. One marks every edge that leaves the idle level. The other marks every edge that returns to the idle level. The shift logic uses them to launch and capture data.

Top module: `spi_sclk_gen`

## Requirements
- R1: With the enable input held high, `sclk_o` toggles once every H system cycles and never in between. H is half the effective divisor: bits [15:1] of `div_i` read as a number, with 0 standing for 32768.
- R2: A divisor setting of 0 gives an effective divisor of 65536, so `sclk_o` first toggles 32768 cycles after enable and again 32768 cycles later.
- R3: Bit 0 of `div_i` has no effect. An odd setting behaves exactly like the even setting one below it, and a setting of 1 behaves like 0 (ratio 65536).
- R4: Settings 2 and 3 give the minimum ratio of 2, so `sclk_o` toggles on every system cycle while enabled.
- R5: While `en_i` is low, `sclk_o` equals `cpol_i` one cycle later, and both `lead_o` and `trail_o` stay low.
- R6: Counting the first clock edge that samples `en_i` high as edge 1, the first toggle of `sclk_o` appears at edge H.
- R7: `lead_o` is high for exactly the cycle in which `sclk_o` first shows the non-idle level (not `cpol`). `trail_o` is high for exactly the cycle in which `sclk_o` returns to the idle level. The two strobes are never high together.
- R8: Changes on `div_i` or `cpol_i` while `en_i` is high do not change the period, phase or idle level of the running transfer. They take effect at the next enable.
- R9: While `rst_ni` is low, `sclk_o`, `lead_o` and `trail_o` are all low.
- R10: If `en_i` drops while `sclk_o` is at its non-idle level, `sclk_o` returns to the idle level at the next edge and no `trail_o` strobe is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Transfer active; low holds the clock at idle |
| div_i | input | 16 | Divisor setting; bit 0 ignored, 0 and 1 mean 65536 |
| cpol_i | input | 1 | Idle level of the serial clock |
| sclk_o | output | 1 | Serial clock pin level |
| lead_o | output | 1 | One-cycle strobe on an edge leaving idle |
| trail_o | output | 1 | One-cycle strobe on an edge returning to idle |

## Verification
All three outputs are registers. A result caused at clock edge k is therefore read on the falling edge that follows edge k. The bench numbers the enabled edges from 1 and predicts the output level at edge k as the polarity XOR (floor(k/H) mod 2), with a strobe only where k is a multiple of H. It compares every cycle of each run against that prediction. Idle-level, divisor-change and abort checks are read on the falling edge right after the edge that registers the change, because each of those results is due one cycle after its stimulus.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;
  localparam int SCLK_DIV_W_DEF = 16;

  typedef enum logic [1:0] {
    EVT_NONE  = 2'd0,
    EVT_LEAD  = 2'd1,
    EVT_TRAIL = 2'd2
  } sclk_evt_e;
endpackage

// File: rtl/sclk_cfg_latch.sv
module sclk_cfg_latch #(
  parameter int DIV_W = 16,
  localparam int CNT_W = DIV_W - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             cpol_i,
  output logic [CNT_W-1:0] lim_o,
  output logic             cpol_o
);
  logic [CNT_W-1:0] half_raw;
  logic [CNT_W-1:0] lim_d, lim_q;
  logic             cpol_d, cpol_q;

  // Bit 0 dropped; a zero half wraps to all ones, i.e. half = 2**CNT_W.
  assign half_raw = div_i[DIV_W-1:1];

  always_comb begin
    lim_d  = lim_q;
    cpol_d = cpol_q;
    if (!en_i) begin
      lim_d  = half_raw - CNT_W'(1);
      cpol_d = cpol_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_q  <= '1;
      cpol_q <= 1'b0;
    end else begin
      lim_q  <= lim_d;
      cpol_q <= cpol_d;
    end
  end

  assign lim_o  = lim_q;
  assign cpol_o = cpol_q;

  // R8
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (!en_i || ($stable(lim_q) && $stable(cpol_q))));
endmodule

// File: rtl/sclk_half_timer.sv
module sclk_half_timer #(
  parameter int CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             at_lim;

  assign at_lim = (cnt_q == lim_i);

  always_comb begin
    if (!en_i)       cnt_d = '0;
    else if (at_lim) cnt_d = '0;
    else             cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign tick_o = en_i && at_lim;

  // R1
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim_i);
endmodule

// File: rtl/sclk_edge_gen.sv
module sclk_edge_gen
  import spi_sclk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic cpol_pin_i,
  input  logic cpol_lat_i,
  output logic sclk_o,
  output logic lead_o,
  output logic trail_o
);
  sclk_evt_e evt;
  logic      sclk_d, sclk_q;
  logic      lead_q, trail_q;

  always_comb begin
    evt    = EVT_NONE;
    sclk_d = sclk_q;
    if (!en_i) begin
      sclk_d = cpol_pin_i;
    end else if (tick_i) begin
      sclk_d = ~sclk_q;
      evt    = (sclk_q == cpol_lat_i) ? EVT_LEAD : EVT_TRAIL;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      sclk_q  <= sclk_d;
      lead_q  <= (evt == EVT_LEAD);
      trail_q <= (evt == EVT_TRAIL);
    end
  end

  assign sclk_o  = sclk_q;
  assign lead_o  = lead_q;
  assign trail_o = trail_q;

  // R7
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lead_q && trail_q));

  // R7
  lead_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_q |-> (sclk_q != cpol_lat_i));

  // R7
  edge_marked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && (sclk_q != $past(sclk_q))) |-> (lead_q || trail_q));

  // R5
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!lead_q && !trail_q));
endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen #(
  parameter int DIV_W = spi_sclk_pkg::SCLK_DIV_W_DEF,
  localparam int CNT_W = DIV_W - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             cpol_i,
  output logic             sclk_o,
  output logic             lead_o,
  output logic             trail_o
);
  logic [CNT_W-1:0] lim;
  logic             cpol_lat;
  logic             tick;

  sclk_cfg_latch #(.DIV_W(DIV_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .div_i  (div_i),
    .cpol_i (cpol_i),
    .lim_o  (lim),
    .cpol_o (cpol_lat)
  );

  sclk_half_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .lim_i  (lim),
    .tick_o (tick)
  );

  sclk_edge_gen u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .tick_i     (tick),
    .cpol_pin_i (cpol_i),
    .cpol_lat_i (cpol_lat),
    .sclk_o     (sclk_o),
    .lead_o     (lead_o),
    .trail_o    (trail_o)
  );

  // R9
  reset_idle_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!sclk_o && !lead_o && !trail_o));
endmodule

// File: tb/sim_spi_sclk_gen.sv
module sim_spi_sclk_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {cpol, div}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b0, 16'd2}, {1'b1, 16'd3}, {1'b0, 16'd4}, {1'b1, 16'd5},
    {1'b1, 16'd6}, {1'b0, 16'd10}, {1'b0, 16'd17}, {1'b1, 16'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] div = 16'd2;
  logic        cpol = 1'b0;
  logic        sclk, lead, trail;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_sclk_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .div_i(div), .cpol_i(cpol),
    .sclk_o(sclk), .lead_o(lead), .trail_o(trail)
  );

  function automatic int half_of(input logic [15:0] d);
    return (d[15:1] == 15'd0) ? 32768 : int'(d[15:1]);
  endfunction

  task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got sclk/lead/trail=%b expected %b", req, got, exp);
    end
  endtask

  // Enable with div d, polarity p; compare every cycle for n edges.
  // At chg_at (>0) the inputs div and cpol are scrambled mid-transfer (R8).
  task automatic run_xfer(input string req, input logic [15:0] d, input logic p,
                          input int n, input int chg_at);
    int h = half_of(d);
    int bad = 0;
    logic [2:0] first_got = '0, first_exp = '0;
    en = 1'b0; div = d; cpol = p;
    repeat (3) @(negedge clk);
    check({req, " idle (R5)"}, {sclk, lead, trail}, {p, 2'b00});
    en = 1'b1;
    for (int k = 1; k <= n; k++) begin
      logic [2:0] e;
      @(negedge clk);
      e[2] = p ^ logic'((k / h) % 2);
      e[1] = (k % h == 0) && ((k / h) % 2 == 1);
      e[0] = (k % h == 0) && ((k / h) % 2 == 0);
      if ({sclk, lead, trail} !== e && bad == 0) begin
        first_got = {sclk, lead, trail};
        first_exp = e;
      end
      if ({sclk, lead, trail} !== e) bad++;
      if (k == chg_at) begin
        div = ~d;
        cpol = ~p;
      end
    end
    check(req, first_got, first_exp);
    en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    // R9: reset state
    repeat (2) @(negedge clk);
    check("R9", {sclk, lead, trail}, 3'b000);
    cpol = 1'b1;
    @(negedge clk);
    check("R9", {sclk, lead, trail}, 3'b000);
    rst_n = 1'b1;
    cpol = 1'b0;

    // Table walk: R1, R4, R6, R7; odd entries R3; zero entry R2
    for (int i = 0; i < NVEC; i++) begin
      int h = half_of(VEC[i][15:0]);
      run_xfer("R1/R6/R7", VEC[i][15:0], VEC[i][16], (h > 1000) ? 2*h + 3 : 4*h + 3, 0);
    end

    // R3: setting 1 behaves like 65536
    run_xfer("R3", 16'd1, 1'b0, 32770, 0);
    // R4: setting 3, minimum ratio
    run_xfer("R4", 16'd3, 1'b0, 9, 0);
    // R8: scramble inputs mid-transfer, pattern must keep half=3
    run_xfer("R8", 16'd6, 1'b0, 14, 4);
    // R8: next enable picks up new value (setting 2)
    run_xfer("R8", 16'd2, 1'b1, 6, 0);

    // R10: abort while non-idle
    en = 1'b0; div = 16'd8; cpol = 1'b1;
    repeat (3) @(negedge clk);
    en = 1'b1;
    repeat (5) @(negedge clk);
    check("R10 active", {sclk, lead, trail}, 3'b000);
    en = 1'b0;
    @(negedge clk);
    check("R10", {sclk, lead, trail}, 3'b100);

    // R5: idle follows polarity one cycle later
    cpol = 1'b0;
    @(negedge clk);
    check("R5", {sclk, lead, trail}, 3'b000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule